// File: doc/BRIEF.md
# Core Memory Read-Restore Sequencer

This block sequences accesses to a stack of magnetic core planes. Every plane is a square grid addressed by one X line and one Y line. The same pair of lines is applied to all planes at once, so one access moves one word across the stack. A host request carries an address, a read/write flag and write data. The block then runs the drive pulses, the sense window and the restore on its own, and it signals completion with a one-cycle done pulse.

Reading a core is destructive. To read, the block drives a clear into the addressed core of every plane at the same time. Each plane's sense input reports, during a strobe window, whether its core flipped. A flip means the core held a one, and it sets that plane's capture flop. Once the clear has ended, every addressed core holds zero. The block then restores the word without the host's help. It issues set pulses one plane at a time, and only for planes that captured a one. A host write uses the same path: a clear whose sense result is discarded, followed by serial set pulses for the one bits of the write data. Analog drivers and sense amplifiers are modelled as digital enables and pulse inputs.

Top module: `core_stack_seq`

## Requirements
- R1: An accepted request starts a clear pulse of DRIVE_CYCLES cycles. During it, drive_en_o is all ones and drive_set_o is 0. x_sel_o is one-hot at X = addr_i[11:6] and y_sel_o is one-hot at Y = addr_i[5:0], both taken from the address at acceptance.
- R2: strobe_o is high only during the first STROBE_CYCLES cycles of a clear pulse. During a read, a sense_i[p] pulse sampled in such a cycle sets rdata_o[p]. A pulse outside the window has no effect.
- R3: The capture flops are sticky. Pulses on different planes in different cycles of the window accumulate into rdata_o.
- R4: After a read clear, each plane p with rdata_o[p]=1 gets exactly one set pulse. That pulse lasts DRIVE_CYCLES cycles, with drive_set_o=1 and drive_en_o one-hot at p. Planes holding 0 get no set pulse.
- R5: Set pulses are issued in ascending plane order.
- R6: A write clears the word and then issues set pulses, as in R4/R5, for each one bit of wdata_i. Sense inputs are ignored during a write, and rdata_o reads zero after it.
- R7: Every pulse, including the last one, is followed by RECOVER_CYCLES cycles in which drive_en_o, x_sel_o, y_sel_o and strobe_o are all zero.
- R8: busy_o is high for exactly (DRIVE_CYCLES+RECOVER_CYCLES)*(1+n) cycles after acceptance, where n is the number of set pulses.
- R9: While busy_o is high, req_i, addr_i, wr_i and wdata_i have no effect on the running sequence, and a request made then is not queued.
- R10: done_o pulses for one cycle, in the first cycle with busy_o low. rdata_o then holds until the next accepted request. A request presented in the done cycle is accepted.
- R11: Under reset, busy_o, done_o, drive_en_o, drive_set_o, strobe_o, x_sel_o, y_sel_o and rdata_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, taken when idle |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | X in [11:6], Y in [5:0] |
| wdata_i | input | 8 | Write data, one bit per plane |
| sense_i | input | 8 | Sense pulses, one per plane |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Captured read word |
| x_sel_o | output | 64 | One-hot X line select |
| y_sel_o | output | 64 | One-hot Y line select |
| drive_en_o | output | 8 | Per-plane drive enable |
| drive_set_o | output | 1 | Drive polarity: 1 = set, 0 = clear |
| strobe_o | output | 1 | Sense window |

## Verification
The done pulse of one access and the acceptance of the next request can fall in the same cycle. The sweeps issue each request at the sampling point where done is observed, so every access in them starts in its predecessor's done cycle. Each such access must show its clear pulse on the very next cycle, with the new address on the lines and no lost or extra cycle. A second overlap exists between a sense pulse and the last strobe cycle. It is provoked by pulses placed on the final window cycle, where they must be captured, and on the first cycle after it, where they must be dropped.

// File: rtl/core_seq_pkg.sv
package core_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CLEAR = 2'd1,
    ST_GAP   = 2'd2,
    ST_SET   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/core_line_dec.sv
module core_line_dec #(
  parameter int SEL_BITS = 6
) (
  input  logic [SEL_BITS-1:0]      sel_i,
  input  logic                     en_i,
  output logic [(1<<SEL_BITS)-1:0] line_o
);
  always_comb begin
    line_o = '0;
    if (en_i) line_o[sel_i] = 1'b1;
  end
endmodule

// File: rtl/core_lsb_pick.sv
module core_lsb_pick #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] req_i,
  output logic [WIDTH-1:0] grant_o
);
  // isolate lowest set bit
  assign grant_o = req_i & (~req_i + WIDTH'(1));
endmodule

// File: rtl/core_stack_seq.sv
module core_stack_seq
  import core_seq_pkg::*;
#(
  parameter int X_BITS         = 6,
  parameter int Y_BITS         = 6,
  parameter int PLANES         = 8,
  parameter int DRIVE_CYCLES   = 3,
  parameter int RECOVER_CYCLES = 2,
  parameter int STROBE_CYCLES  = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic                     wr_i,
  input  logic [X_BITS+Y_BITS-1:0] addr_i,
  input  logic [PLANES-1:0]        wdata_i,
  input  logic [PLANES-1:0]        sense_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic [PLANES-1:0]        rdata_o,
  output logic [(1<<X_BITS)-1:0]   x_sel_o,
  output logic [(1<<Y_BITS)-1:0]   y_sel_o,
  output logic [PLANES-1:0]        drive_en_o,
  output logic                     drive_set_o,
  output logic                     strobe_o
);
  localparam int ADDR_BITS = X_BITS + Y_BITS;
  localparam int CNT_MAX   = (DRIVE_CYCLES > RECOVER_CYCLES) ? DRIVE_CYCLES : RECOVER_CYCLES;
  localparam int CNT_BITS  = $clog2(CNT_MAX + 1);

  seq_state_e           state_q;
  logic [CNT_BITS-1:0]  cnt_q;
  logic [ADDR_BITS-1:0] addr_q;
  logic                 wr_q;
  logic [PLANES-1:0]    wdata_q;
  logic [PLANES-1:0]    cap_q;
  logic [PLANES-1:0]    pend_q;
  logic [PLANES-1:0]    sel_q;
  logic                 done_q;

  logic                 in_clear, in_set, drive_on, pulse_end, gap_end;
  logic [PLANES-1:0]    cap_nxt, pick;

  assign in_clear  = (state_q == ST_CLEAR);
  assign in_set    = (state_q == ST_SET);
  assign drive_on  = in_clear | in_set;
  assign pulse_end = (cnt_q == CNT_BITS'(DRIVE_CYCLES - 1));
  assign gap_end   = (cnt_q == CNT_BITS'(RECOVER_CYCLES - 1));
  assign strobe_o  = in_clear && (cnt_q < CNT_BITS'(STROBE_CYCLES));
  // sense result of a write clear is discarded
  assign cap_nxt   = cap_q | ((strobe_o && !wr_q) ? sense_i : '0);

  core_lsb_pick #(.WIDTH(PLANES)) u_pick (
    .req_i   (pend_q),
    .grant_o (pick)
  );

  core_line_dec #(.SEL_BITS(X_BITS)) u_xdec (
    .sel_i  (addr_q[ADDR_BITS-1:Y_BITS]),
    .en_i   (drive_on),
    .line_o (x_sel_o)
  );

  core_line_dec #(.SEL_BITS(Y_BITS)) u_ydec (
    .sel_i  (addr_q[Y_BITS-1:0]),
    .en_i   (drive_on),
    .line_o (y_sel_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      cap_q   <= '0;
      pend_q  <= '0;
      sel_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_i) begin
            addr_q  <= addr_i;
            wr_q    <= wr_i;
            wdata_q <= wdata_i;
            cap_q   <= '0;
            cnt_q   <= '0;
            state_q <= ST_CLEAR;
          end
        end
        ST_CLEAR: begin
          cap_q <= cap_nxt;
          if (pulse_end) begin
            pend_q  <= wr_q ? wdata_q : cap_nxt;
            cnt_q   <= '0;
            state_q <= ST_GAP;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_GAP: begin
          if (gap_end) begin
            cnt_q <= '0;
            if (pend_q == '0) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              sel_q   <= pick;
              state_q <= ST_SET;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_SET: begin
          if (pulse_end) begin
            pend_q  <= pend_q & ~sel_q;
            cnt_q   <= '0;
            state_q <= ST_GAP;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign rdata_o     = cap_q;
  assign drive_set_o = in_set;
  assign drive_en_o  = in_clear ? {PLANES{1'b1}} : (in_set ? sel_q : '0);
endmodule

// File: rtl/core_stack_seq_chk.sv
module core_stack_seq_chk #(
  parameter int X_BITS = 6,
  parameter int Y_BITS = 6,
  parameter int PLANES = 8
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   req_i,
  input logic                   busy_o,
  input logic                   done_o,
  input logic [PLANES-1:0]      rdata_o,
  input logic [(1<<X_BITS)-1:0] x_sel_o,
  input logic [(1<<Y_BITS)-1:0] y_sel_o,
  input logic [PLANES-1:0]      drive_en_o,
  input logic                   drive_set_o,
  input logic                   strobe_o
);
  AST_ONE_LINE_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_en_o != '0) |-> ($countones(x_sel_o) == 1 && $countones(y_sel_o) == 1)); // R1
  AST_STROBE_IN_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> (drive_en_o == {PLANES{1'b1}} && !drive_set_o)); // R2
  AST_SET_ONE_PLANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_set_o |-> ($countones(drive_en_o) == 1)); // R4
  AST_GAP_LINES_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_en_o == '0) |-> (x_sel_o == '0 && y_sel_o == '0 && !strobe_o)); // R7
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(busy_o) && !busy_o)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !req_i) |=> $stable(rdata_o)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (drive_en_o == '0 && !drive_set_o)); // R11
endmodule

bind core_stack_seq core_stack_seq_chk #(
  .X_BITS(X_BITS), .Y_BITS(Y_BITS), .PLANES(PLANES)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .busy_o(busy_o), .done_o(done_o),
  .rdata_o(rdata_o), .x_sel_o(x_sel_o), .y_sel_o(y_sel_o), .drive_en_o(drive_en_o),
  .drive_set_o(drive_set_o), .strobe_o(strobe_o)
);

// File: tb/core_stack_seq_tb.sv
module core_stack_seq_tb;
  localparam int D = 3;
  localparam int R = 2;
  localparam int S = 2;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  sense_i = '0;
  logic        busy_o, done_o, drive_set_o, strobe_o;
  logic [7:0]  rdata_o, drive_en_o;
  logic [63:0] x_sel_o, y_sel_o;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk_i = ~clk_i;

  core_stack_seq #(
    .X_BITS(6), .Y_BITS(6), .PLANES(8),
    .DRIVE_CYCLES(D), .RECOVER_CYCLES(R), .STROBE_CYCLES(S)
  ) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .sense_i(sense_i), .busy_o(busy_o), .done_o(done_o),
    .rdata_o(rdata_o), .x_sel_o(x_sel_o), .y_sel_o(y_sel_o), .drive_en_o(drive_en_o),
    .drive_set_o(drive_set_o), .strobe_o(strobe_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // one access; expects to be entered at a negedge
  task automatic run_op(input logic wr, input logic [11:0] addr, input logic [7:0] wd,
                        input logic [7:0] pat_a, input int k_a,
                        input logic [7:0] pat_b, input int k_b,
                        input int poke_k, input logic [7:0] exp_rd, input string req);
    logic [7:0] mask;
    int n, exp_len, k, errs;
    longint first_act, first_exp;
    mask = wr ? wd : exp_rd;
    n = $countones(mask);
    exp_len = (D + R) * (n + 1);
    req_i = 1'b1; wr_i = wr; addr_i = addr; wdata_i = wd;
    @(posedge clk_i); @(negedge clk_i);
    req_i = 1'b0; wr_i = ~wr; addr_i = ~addr; wdata_i = ~wd;
    k = 0; errs = 0; first_act = 0; first_exp = 0;
    while (busy_o && k < 1000) begin
      int seg, off, cnt;
      logic [7:0] een;
      logic eset, estb, edrv;
      logic [63:0] ex, ey;
      seg = k / (D + R);
      off = k % (D + R);
      cnt = 0;
      if (off >= D) begin
        een = '0; eset = 0; estb = 0; edrv = 0;
      end else if (seg == 0) begin
        een = 8'hFF; eset = 0; estb = (off < S); edrv = 1;
      end else begin
        een = '0; eset = 1; estb = 0; edrv = 1;
        for (int p = 0; p < 8; p++) begin
          if (mask[p]) begin
            cnt++;
            if (cnt == seg) een = 8'(1 << p);
          end
        end
      end
      ex = edrv ? (64'd1 << addr[11:6]) : '0;
      ey = edrv ? (64'd1 << addr[5:0]) : '0;
      if (drive_en_o !== een || drive_set_o !== eset || strobe_o !== estb ||
          x_sel_o !== ex || y_sel_o !== ey) begin
        if (errs == 0) begin
          first_act = {39'd0, drive_set_o, strobe_o, drive_en_o, 14'd0, k[9:0]};
          first_exp = {39'd0, eset, estb, een, 14'd0, k[9:0]};
        end
        errs++;
      end
      sense_i = ((k == k_a) ? pat_a : 8'h00) | ((k == k_b) ? pat_b : 8'h00);
      req_i = (k == poke_k);
      k++;
      @(negedge clk_i);
    end
    sense_i = '0; req_i = 1'b0;
    check(errs == 0, "R1 R4 R5 R7", {req, " pulse sequence"}, first_act, first_exp);
    check(k == exp_len, "R8", {req, " busy length"}, k, exp_len);
    check(done_o == 1'b1, "R10", {req, " done pulse"}, done_o, 1);
    check(rdata_o == exp_rd, req, "read data", rdata_o, exp_rd);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd_hold;
    repeat (3) @(negedge clk_i);
    // R11 reset state
    check(!busy_o && !done_o && !drive_set_o && !strobe_o, "R11", "reset controls",
          {busy_o, done_o, drive_set_o, strobe_o}, 0);
    check(drive_en_o == 0 && x_sel_o == 0 && y_sel_o == 0 && rdata_o == 0, "R11",
          "reset drives", drive_en_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 R4 R5: all patterns, pulse on each window cycle; each starts in prior done cycle
    for (int pat = 0; pat < 256; pat++)
      run_op(1'b0, 12'((pat * 37 + 5) % 4096), 8'h00, 8'(pat), pat % S, 8'h00, -1,
             -1, 8'(pat), "R2");

    // R3 sticky accumulation across window cycles
    for (int pat = 0; pat < 256; pat += 17)
      run_op(1'b0, 12'(pat * 11), 8'h00, 8'(pat) & 8'h0F, 0, 8'(pat) & 8'hF0, S - 1,
             -1, 8'(pat), "R3");
    run_op(1'b0, 12'hABC, 8'h00, 8'h81, 0, 8'h81, 1, -1, 8'h81, "R3");

    // R2 pulses outside the window ignored
    run_op(1'b0, 12'hFFF, 8'h00, 8'hFF, S, 8'hFF, D - 1, -1, 8'h00, "R2");
    run_op(1'b0, 12'h000, 8'h00, 8'h3C, 0, 8'hC3, S, -1, 8'h3C, "R2");

    // R6 writes with sense noise that must be ignored
    for (int wd = 0; wd < 256; wd += 5)
      run_op(1'b1, 12'(wd * 97 % 4096), 8'(wd), 8'hFF, 0, 8'hFF, 1, -1, 8'h00, "R6");

    // R9 request while busy ignored, no queued access
    run_op(1'b0, 12'h555, 8'h00, 8'h24, 1, 8'h00, -1, 2, 8'h24, "R9");
    run_op(1'b1, 12'h2AA, 8'h90, 8'h00, -1, 8'h00, -1, 4, 8'h00, "R9");
    @(negedge clk_i);
    check(!busy_o, "R9", "no queued access after busy poke", busy_o, 0);

    // R10 hold after done, idle cycles
    run_op(1'b0, 12'h123, 8'h00, 8'h5A, 0, 8'h00, -1, -1, 8'h5A, "R10");
    rd_hold = rdata_o;
    repeat (4) @(negedge clk_i);
    check(rdata_o == rd_hold && !done_o && !busy_o, "R10", "hold while idle",
          rdata_o, rd_hold);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule